// File: doc/BRIEF.md
# DRAM Page-Mode Cycle Classifier

This block sits in front of a DRAM controller. It keeps a record of which row is open in each of eight DRAM banks. For every memory request it sorts the access into one of three timing classes. A page hit means the bank's row strobe is already low on the wanted row. A RAS-high access means the bank has no open row. A page miss means the bank is open on a different row. From the class it derives a wait-state count and the total number of bus T-states for the cycle.

The block supports two row-activation policies. With several banks open at once, each bank keeps its own open row, so returning to a bank that is still open costs no more than a page hit. With a single open bank, any change of bank closes the bank used before.

Bank sizes are set per bank by a 2-bit code. When banks 0–3, or banks 4–7, all hold the same non-zero size, consecutive DRAM pages rotate across the four banks of that group. Each request is accepted with a valid strobe. The classification comes back one cycle later together with a one-cycle result strobe.

Top module: `dpm_cycle_classifier`

## Requirements
- R1: After reset `res_valid` is low and every bank is closed, so the first access to any bank is classified RAS-high (`res_type` = 1).
- R2: A request accepted with `req_valid` high at a clock edge produces `res_valid` high for exactly the following cycle. Without a request, `res_valid` stays low.
- R3: With `cfg_multi_ras` = 1 each bank keeps its own open row. An access to an open bank on its open row is a page hit (`res_type` = 0), even right after accesses to other banks.
- R4: An access to an open bank on a different row is a page miss (`res_type` = 2), and that row becomes the bank's open row.
- R5: With `cfg_multi_ras` = 0 only the most recently accessed bank stays open. An access to any other bank is RAS-high, and the bank used before is closed.
- R6: A page-hit read has 0 wait states. A page-hit write has 1.
- R7: A RAS-high access, read or write, has 1 wait state when `cfg_ras_encoded` = 0 and 2 when it is 1. A page miss has 3.
- R8: `res_tstates` equals the wait states plus 2 when `req_pipelined` = 1, and plus 3 when it is 0.
- R9: One extra T-state is added only when both `req_xlat` and `cfg_xlat_en` are 1.
- R10: When the size codes of banks 0–3 (`cfg_bank_size` bits [2i+1:2i] for bank i) are equal and non-zero, an address below the end of bank 3 with group-relative page number p (address / 2^COL_W) goes to bank p mod 4 with row p / 4.
- R11: When banks 4–7 have equal non-zero size codes, the same rotation applies inside their region: page p counted from the start of bank 4 goes to bank 4 + p mod 4 with row p / 4.
- R12: Outside an interleaved group, banks occupy consecutive address ranges in bank order. Bank i holds 0 bytes for code 0 and 2^(SZ_BASE+code-1) bytes otherwise. The row is the offset within the bank divided by 2^COL_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_multi_ras | input | 1 | 1: several banks open at once; 0: one open bank |
| cfg_ras_encoded | input | 1 | Row strobes are encoded (longer RAS-high cycles) |
| cfg_xlat_en | input | 1 | Address translation feature enabled |
| cfg_bank_size | input | 16 | 2-bit size code per bank, bank i at bits [2i+1:2i] |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Physical request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_pipelined | input | 1 | Request is a pipelined bus cycle |
| req_xlat | input | 1 | Request needs address translation |
| res_valid | output | 1 | One-cycle result strobe |
| res_type | output | 2 | 0 page hit, 1 RAS-high, 2 page miss |
| res_bank | output | 3 | Target bank |
| res_row | output | ADDR_W-COL_W | Target row |
| res_wait | output | 2 | Wait-state count |
| res_tstates | output | 3 | Total T-states of the cycle |

## Verification
The hardest case to reach is a return to a bank that was left open several accesses earlier while other banks were used in between. This case exposes the difference between the two activation policies and also catches an open-row table that gets overwritten or cleared at the wrong time. The stimulus walks through short runs of addresses one interleave page apart, then comes back to the starting address. It does this under both policies, and it repeats the pattern in a long random phase. That phase draws addresses from a handful of hot pages and switches policy at random, so the reference model and the design must agree on state that was built up under the other policy.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  localparam int NBANK = 8;
  localparam int GRP   = 4;

  typedef enum logic [1:0] {
    CYC_HIT   = 2'd0,
    CYC_RASHI = 2'd1,
    CYC_MISS  = 2'd2
  } cyc_e;

  // wait states from class, direction and row-strobe encoding
  function automatic logic [1:0] wait_states(cyc_e c, logic wr, logic enc);
    logic [1:0] ws;
    case (c)
      CYC_HIT:   ws = wr  ? 2'd1 : 2'd0;
      CYC_RASHI: ws = enc ? 2'd2 : 2'd1;
      default:   ws = 2'd3;
    endcase
    return ws;
  endfunction

  // total bus states: base of 2 (pipelined) or 3, plus translation penalty
  function automatic logic [2:0] total_states(logic [1:0] ws, logic pipe, logic extra);
    logic [2:0] base;
    base = pipe ? 3'd2 : 3'd3;
    return {1'b0, ws} + base + {2'b00, extra};
  endfunction

endpackage

// File: rtl/dpm_bank_map.sv
module dpm_bank_map
  import dpm_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int COL_W   = 9,
  parameter int SZ_BASE = 18,
  localparam int ROW_W  = ADDR_W - COL_W,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [2*NBANK-1:0]   size_cfg_i,
  output logic [BANK_W-1:0]    bank_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [1:0]           ilv_o
);

  logic [1:0]      sz   [NBANK];
  logic [ADDR_W:0] bsz  [NBANK];
  logic [ADDR_W:0] base [NBANK+1];
  logic [1:0]      ilv;

  for (genvar i = 0; i < NBANK; i++) begin : g_size
    assign sz[i]  = size_cfg_i[2*i +: 2];
    assign bsz[i] = (sz[i] == 2'd0) ? '0
                  : ((ADDR_W+1)'(1) << (SZ_BASE + int'(sz[i]) - 1));
  end

  // a group interleaves when its four banks share one non-zero size
  for (genvar g = 0; g < NBANK/GRP; g++) begin : g_grp
    assign ilv[g] = (sz[GRP*g] != 2'd0)
                 && (sz[GRP*g] == sz[GRP*g+1])
                 && (sz[GRP*g] == sz[GRP*g+2])
                 && (sz[GRP*g] == sz[GRP*g+3]);
  end
  assign ilv_o = ilv;

  logic [ADDR_W:0]   a_ext;
  logic [ADDR_W:0]   off;
  logic [ADDR_W:0]   goff;
  logic [BANK_W-1:0] lin_bank;

  assign a_ext = {1'b0, addr_i};

  always_comb begin
    base[0] = '0;
    for (int i = 0; i < NBANK; i++) base[i+1] = base[i] + bsz[i];
  end

  always_comb begin
    lin_bank = '0;
    off      = a_ext;
    for (int i = 0; i < NBANK; i++) begin
      if (a_ext >= base[i] && a_ext < base[i+1]) begin
        lin_bank = BANK_W'(i);
        off      = a_ext - base[i];
      end
    end
  end

  always_comb begin
    goff = a_ext - base[GRP*int'(lin_bank[BANK_W-1])];
    if (ilv[lin_bank[BANK_W-1]]) begin
      bank_o = {lin_bank[BANK_W-1], goff[COL_W+1:COL_W]};
      row_o  = ROW_W'(goff >> (COL_W + 2));
    end else begin
      bank_o = lin_bank;
      row_o  = ROW_W'(off >> COL_W);
    end
  end

endmodule

// File: rtl/dpm_row_track.sv
module dpm_row_track
  import dpm_pkg::*;
#(
  parameter int ROW_W = 15,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              multi_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  output cyc_e              cls_o
);

  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] row_q [NBANK];

  // named events for the checks below
  logic tgt_open;
  logic row_match;
  assign tgt_open  = open_q[bank_i];
  assign row_match = (row_q[bank_i] == row_i);

  always_comb begin
    if (!tgt_open)      cls_o = CYC_RASHI;
    else if (row_match) cls_o = CYC_HIT;
    else                cls_o = CYC_MISS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
    end else if (fire_i) begin
      if (multi_i) open_q[bank_i] <= 1'b1;
      else         open_q <= NBANK'(1) << bank_i;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              row_q[b] <= '0;
      else if (fire_i && bank_i == BANK_W'(b)) row_q[b] <= row_i;
    end
  end

  // R5: one open bank at most after a single-bank-policy access
  p_single_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !multi_i) |=> $onehot0(open_q));

  // R4: the accessed bank is open on the accessed row afterwards
  p_row_installed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (open_q[$past(bank_i)] && row_q[$past(bank_i)] == $past(row_i)));

  // R1: nothing is open in the cycle right after reset is released
  p_closed_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (open_q == '0));

endmodule

// File: rtl/dpm_cycle_classifier.sv
module dpm_cycle_classifier
  import dpm_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int COL_W   = 9,
  parameter int SZ_BASE = 18,
  localparam int ROW_W  = ADDR_W - COL_W,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_multi_ras,
  input  logic                 cfg_ras_encoded,
  input  logic                 cfg_xlat_en,
  input  logic [2*NBANK-1:0]   cfg_bank_size,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic                 req_pipelined,
  input  logic                 req_xlat,
  output logic                 res_valid,
  output logic [1:0]           res_type,
  output logic [BANK_W-1:0]    res_bank,
  output logic [ROW_W-1:0]     res_row,
  output logic [1:0]           res_wait,
  output logic [2:0]           res_tstates
);

  logic [BANK_W-1:0] map_bank;
  logic [ROW_W-1:0]  map_row;
  logic [1:0]        map_ilv;
  cyc_e              cls;
  logic [1:0]        ws_c;
  logic [2:0]        ts_c;
  logic              xlat_pen;

  dpm_bank_map #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .SZ_BASE(SZ_BASE)
  ) u_map (
    .addr_i    (req_addr),
    .size_cfg_i(cfg_bank_size),
    .bank_o    (map_bank),
    .row_o     (map_row),
    .ilv_o     (map_ilv)
  );

  dpm_row_track #(
    .ROW_W(ROW_W)
  ) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (req_valid),
    .multi_i(cfg_multi_ras),
    .bank_i (map_bank),
    .row_i  (map_row),
    .cls_o  (cls)
  );

  assign xlat_pen = req_xlat & cfg_xlat_en;
  assign ws_c     = wait_states(cls, req_write, cfg_ras_encoded);
  assign ts_c     = total_states(ws_c, req_pipelined, xlat_pen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_type    <= CYC_RASHI;
      res_bank    <= '0;
      res_row     <= '0;
      res_wait    <= '0;
      res_tstates <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_type    <= cls;
        res_bank    <= map_bank;
        res_row     <= map_row;
        res_wait    <= ws_c;
        res_tstates <= ts_c;
      end
    end
  end

  // R2: result strobe follows each request by one cycle
  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  // R6: a page hit never costs more than one wait state
  p_hit_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_type == CYC_HIT) |-> (res_wait <= 2'd1));

  // R7: a page miss always costs three wait states
  p_miss_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_type == CYC_MISS) |-> (res_wait == 2'd3));

  // R8: total states lie between wait+2 and wait+4
  p_state_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((4'(res_tstates) >= 4'(res_wait) + 4'd2) &&
                   (4'(res_tstates) <= 4'(res_wait) + 4'd4)));

  // R10: an interleaved low group never routes to the high banks
  p_low_group_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && map_ilv[0] && map_bank[BANK_W-1] == 1'b0) |=> (res_bank < BANK_W'(4)));

endmodule

// File: tb/sim_dpm_cycle_classifier.sv
`timescale 1ns/1ps
module sim_dpm_cycle_classifier;

  localparam int ADDR_W = 24;
  localparam int COL_W  = 9;
  localparam int SZB    = 18;
  localparam int ROW_W  = ADDR_W - COL_W;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_multi_ras = 1, cfg_ras_encoded = 0, cfg_xlat_en = 0;
  logic [15:0] cfg_bank_size = '0;
  logic req_valid = 0, req_write = 0, req_pipelined = 0, req_xlat = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic res_valid;
  logic [1:0] res_type, res_wait;
  logic [2:0] res_bank, res_tstates;
  logic [ROW_W-1:0] res_row;

  always #2.5 clk = ~clk;

  dpm_cycle_classifier u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_multi_ras(cfg_multi_ras), .cfg_ras_encoded(cfg_ras_encoded),
    .cfg_xlat_en(cfg_xlat_en), .cfg_bank_size(cfg_bank_size),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_pipelined(req_pipelined), .req_xlat(req_xlat),
    .res_valid(res_valid), .res_type(res_type), .res_bank(res_bank),
    .res_row(res_row), .res_wait(res_wait), .res_tstates(res_tstates)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference state: open flag and row per bank
  bit m_open [8];
  int m_row  [8];

  function automatic int bytes_of(int code);
    if (code == 0) return 0;
    return 1 << (SZB + code - 1);
  endfunction

  task automatic m_clear();
    foreach (m_open[i]) begin m_open[i] = 0; m_row[i] = 0; end
  endtask

  // behavioural model: decode, classify, cost, update
  task automatic model(input int a, input bit wr, input bit pp, input bit xl,
                       output int b, output int r, output int t,
                       output int ws, output int ts);
    int lo, sizes[8], starts[9];
    bit grp_eq[2];
    starts[0] = 0;
    for (int i = 0; i < 8; i++) begin
      sizes[i] = bytes_of(int'(cfg_bank_size[2*i +: 2]));
      starts[i+1] = starts[i] + sizes[i];
    end
    for (int g = 0; g < 2; g++)
      grp_eq[g] = sizes[4*g] != 0 && sizes[4*g] == sizes[4*g+1] &&
                  sizes[4*g] == sizes[4*g+2] && sizes[4*g] == sizes[4*g+3];
    b = 0; lo = 0;
    for (int i = 0; i < 8; i++)
      if (a >= starts[i] && a < starts[i+1]) b = i;
    if (grp_eq[b/4]) begin
      lo = a - starts[(b/4)*4];
      r  = (lo / (1 << COL_W)) / 4;
      b  = (b/4)*4 + (lo / (1 << COL_W)) % 4;
    end else begin
      r = (a - starts[b]) / (1 << COL_W);
    end
    if (!m_open[b])         begin t = 1; ws = cfg_ras_encoded ? 2 : 1; end
    else if (m_row[b] == r) begin t = 0; ws = wr ? 1 : 0; end
    else                    begin t = 2; ws = 3; end
    ts = ws + (pp ? 2 : 3) + ((xl && cfg_xlat_en) ? 1 : 0);
    if (!cfg_multi_ras) foreach (m_open[i]) m_open[i] = 0;
    m_open[b] = 1;
    m_row[b]  = r;
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // issue one request; compare at the following falling edge
  task automatic issue(input int a, input bit wr, input bit pp, input bit xl,
                       input string req, input int exp_type);
    int b, r, t, ws, ts;
    req_valid = 1; req_addr = a[ADDR_W-1:0]; req_write = wr;
    req_pipelined = pp; req_xlat = xl;
    model(a, wr, pp, xl, b, r, t, ws, ts);
    if (exp_type >= 0) check(req, t, exp_type, "model class vs requirement");
    @(negedge clk);
    req_valid = 0;
    check(req, int'(res_valid), 1, "res_valid");
    check(req, int'(res_type), t, "res_type");
    check(req, int'(res_bank), b, "res_bank");
    check(req, int'(res_row), r, "res_row");
    check(req, int'(res_wait), ws, "res_wait");
    check(req, int'(res_tstates), ts, "res_tstates");
  endtask

  task automatic idle(input string req);
    req_valid = 0;
    @(negedge clk);
    check(req, int'(res_valid), 0, "res_valid idle");
  endtask

  task automatic do_reset();
    req_valid = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    m_clear();
    check("R1", int'(res_valid), 0, "res_valid in reset");
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    // banks 0-3 256K each (interleaved), 4: 512K, 5: 256K, 6: 1M, 7 empty
    cfg_bank_size = {2'd0, 2'd3, 2'd1, 2'd2, 2'd1, 2'd1, 2'd1, 2'd1};
    @(negedge clk);
    do_reset();
    idle("R1");

    // several-banks-open policy
    issue(32'h000, 0, 0, 0, "R1", 1);
    issue(32'h004, 0, 0, 0, "R6", 0);
    issue(32'h200, 1, 0, 0, "R10", 1);
    issue(32'h400, 0, 0, 0, "R10", 1);
    issue(32'h010, 0, 0, 0, "R3", 0);
    issue(32'h208, 1, 0, 0, "R6", 0);
    issue(32'h800, 0, 0, 0, "R4", 2);
    issue(32'h000, 1, 0, 0, "R4", 2);
    idle("R2");
    idle("R2");
    issue(32'h004, 0, 1, 0, "R8", 0);
    issue(32'h100000, 0, 1, 0, "R12", 1);
    issue(32'h180200, 0, 0, 0, "R12", 1);
    issue(32'h1C0400, 0, 0, 0, "R12", 1);
    issue(32'h100600, 0, 0, 0, "R12", 2);

    // encoded row strobes and translation penalty
    cfg_ras_encoded = 1;
    issue(32'h600, 1, 0, 1, "R7", 1);
    cfg_xlat_en = 1;
    issue(32'h604, 0, 0, 1, "R9", 0);
    issue(32'h1C0000, 0, 1, 1, "R9", 2);
    cfg_xlat_en = 0;
    cfg_ras_encoded = 0;

    // single-open-bank policy
    cfg_multi_ras = 0;
    do_reset();
    issue(32'h000, 0, 0, 0, "R1", 1);
    issue(32'h004, 0, 0, 0, "R5", 0);
    issue(32'h200, 0, 0, 0, "R5", 1);
    issue(32'h000, 0, 0, 0, "R5", 1);
    issue(32'h800, 0, 0, 0, "R5", 2);

    // all banks equal: upper group interleaves too
    cfg_multi_ras = 1;
    cfg_bank_size = {8{2'd1}};
    do_reset();
    issue(32'h100600, 0, 0, 0, "R11", 1);
    issue(32'h100800, 0, 0, 0, "R11", 1);
    issue(32'h100000, 0, 0, 0, "R11", 2);
    issue(32'h100604, 1, 1, 0, "R11", 0);

    // random phase around a few hot pages, policy switched at random
    for (int k = 0; k < 3000; k++) begin
      int a;
      if ($urandom_range(0, 15) == 0) cfg_multi_ras = ~cfg_multi_ras;
      if ($urandom_range(0, 31) == 0) cfg_ras_encoded = ~cfg_ras_encoded;
      if ($urandom_range(0, 31) == 0) cfg_xlat_en = ~cfg_xlat_en;
      a = $urandom_range(0, 11) * 32'h200 + $urandom_range(0, 3) * 32'h4000
          + $urandom_range(0, 1) * 32'h100000 + $urandom_range(0, 127) * 4;
      if ($urandom_range(0, 4) == 0) idle("R2");
      issue(a, 1'($urandom), 1'($urandom), 1'($urandom), "R3", -1);
    end
    idle("R2");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule